// File: doc/BRIEF.md
# Peripheral and System Clock Gate Controller

This block decides which embedded peripherals and which system clock consumers receive the master clock. Software turns clocks on and off through a small register bus. Each group of clocks has three registers. The first is a write-one-to-set enable register. The second is a write-one-to-clear disable register. The third is a read-only status register that returns the current enable state. Writing a 0 to a set or clear register leaves the matching bit unchanged. Several clocks can therefore be changed in one write without touching the others.

Bit `i` of the peripheral registers drives gated output `periph_clk[i]`. The index is the peripheral identifier, which normally equals that peripheral's interrupt source number. System clock bit 0 is the USB host clock. Its source PLL must be locked before this clock may run: an enable request made while the PLL is unlocked is dropped, and loss of lock forces the bit off. Every gated output passes through a latch-based gate on the master clock. A change of enable state therefore takes effect at a clean clock boundary and never clips a pulse.

Top module: `pclk_ctrl`

## Requirements
- R1: A write to address 4 sets each peripheral enable bit whose write-data bit is 1. Bits written as 0 keep their previous state.
- R2: A write to address 5 clears each peripheral enable bit whose write-data bit is 1. Bits written as 0 keep their previous state.
- R3: A read of address 6 returns the peripheral enable state. A read of address 2 returns the system enable state in the low bits, with zeros above them. Any other read address returns 0. Writes to addresses 2, 3, 6 and 7 change no state.
- R4: Updates to the enable state take effect at the rising edge where the write is sampled. The gated output still carries the pulse that begins at that edge. Every pulse from the following rising edge onward follows the new state, so a disabled clock stops immediately.
- R5: Peripheral bits 0 and 1 are reserved. They always read 0 in the status register, and their gated outputs never pulse.
- R6: While reset is high at a rising edge, all peripheral and system enable bits clear to 0.
- R7: Addresses 0 and 1 set and clear system clock bits in the same write-one manner as R1 and R2. Bit 1 is a system clock that needs no lock.
- R8: System bit 0, the USB host clock, is set only if `pll_lock` is high in the write cycle. It clears in any cycle where `pll_lock` is low, and this clearing wins over a simultaneous enable write.
- R9: Gated output bit `i` pulses high during the high phase of `mclk` exactly when enable bit `i` is 1, for both the peripheral and the system groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock; also clocks the register bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pll_lock | input | 1 | Lock indication from the USB clock source PLL |
| periph_clk | output | 32 | Gated master clock for each peripheral, indexed by identifier |
| sys_clk | output | 2 | Gated system clocks; bit 0 is the USB host clock |

## Verification
The hardest case to reach is a loss of PLL lock in the same cycle as a USB enable write. The bench drops `pll_lock` and strobes the write on one falling edge, then checks that the bit stays clear and that the USB output stays quiet. The exact cycle in which a disable takes effect is also hard to pin down, because only the high phase shows a pulse. The bench therefore samples the gated outputs inside the high phase of the edge that captures the write, where the old state still shows. It samples again one edge later, where the new state must appear.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SYS_SET  = 3'd0,
        A_SYS_CLR  = 3'd1,
        A_SYS_STAT = 3'd2,
        A_PER_SET  = 3'd4,
        A_PER_CLR  = 3'd5,
        A_PER_STAT = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic              set;
        logic              clr;
        logic [DATA_W-1:0] data;
    } wr_cmd_t;

    function automatic logic is_addr(logic [ADDR_W-1:0] a, reg_addr_e r);
        return a == ADDR_W'(r);
    endfunction

endpackage

// File: rtl/pclk_bus_decode.sv
module pclk_bus_decode
    import pclk_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output wr_cmd_t           sys_cmd,
    output wr_cmd_t           per_cmd
);

    always_comb begin
        sys_cmd.set  = wr && is_addr(addr, A_SYS_SET);
        sys_cmd.clr  = wr && is_addr(addr, A_SYS_CLR);
        sys_cmd.data = wdata;
        per_cmd.set  = wr && is_addr(addr, A_PER_SET);
        per_cmd.clr  = wr && is_addr(addr, A_PER_CLR);
        per_cmd.data = wdata;
    end

endmodule

// File: rtl/pclk_enable_bank.sv
module pclk_enable_bank #(
    parameter int             W         = 32,
    parameter logic [W-1:0]   RSV_MASK  = '0,
    parameter logic [W-1:0]   LOCK_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set,
    input  logic         clr,
    input  logic [W-1:0] data,
    input  logic         lock,
    output logic [W-1:0] q
);

    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;
    logic [W-1:0] allow;
    logic [W-1:0] q_next;

    always_comb begin
        set_bits = set ? data : '0;
        clr_bits = clr ? data : '0;
        allow    = ~RSV_MASK & (lock ? {W{1'b1}} : ~LOCK_MASK);
        q_next   = ((q | set_bits) & ~clr_bits) & allow;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_next;
    end

    // R6: reset clears every enable bit
    p_reset_clear_r6: assert property (@(posedge clk) rst |=> (q == '0));

    // R5: reserved positions never hold a 1
    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (q & RSV_MASK) == '0);

    // R1: a set write (with lock present) turns on every written non-reserved bit
    p_set_takes_r1: assert property (@(posedge clk) disable iff (rst)
        (set && lock) |=> ((q & $past(data & ~RSV_MASK)) == $past(data & ~RSV_MASK)));

    // R2: a clear write turns off every written bit
    p_clr_takes_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((q & $past(data)) == '0));

    // R8: lock-dependent bits cannot be on after a cycle without lock
    p_lock_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !lock |=> ((q & LOCK_MASK) == '0));

endmodule

// File: rtl/pclk_gate.sv
module pclk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    logic en_hold;

    // transparent only while clk is low, so the enable cannot change mid-pulse
    always_latch begin
        if (!clk) en_hold = en;
    end

    assign gclk = clk & en_hold;

endmodule

// File: rtl/pclk_ctrl.sv
module pclk_ctrl
    import pclk_pkg::*;
#(
    parameter int          N_PERIPH  = 32,
    parameter int          N_SYS     = 2,
    parameter logic [31:0] PER_RSV   = 32'h0000_0003,
    parameter logic [31:0] SYS_LOCKM = 32'h0000_0001
) (
    input  logic              mclk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pll_lock,
    output logic [N_PERIPH-1:0] periph_clk,
    output logic [N_SYS-1:0]    sys_clk
);

    localparam logic [N_PERIPH-1:0] PER_RSV_W   = PER_RSV[N_PERIPH-1:0];
    localparam logic [N_SYS-1:0]    SYS_LOCKM_W = SYS_LOCKM[N_SYS-1:0];

    wr_cmd_t sys_cmd;
    wr_cmd_t per_cmd;
    logic [N_SYS-1:0]    sys_q;
    logic [N_PERIPH-1:0] per_q;

    pclk_bus_decode u_dec (
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .sys_cmd (sys_cmd),
        .per_cmd (per_cmd)
    );

    pclk_enable_bank #(
        .W         (N_SYS),
        .RSV_MASK  ('0),
        .LOCK_MASK (SYS_LOCKM_W)
    ) u_sys_bank (
        .clk  (mclk),
        .rst  (rst),
        .set  (sys_cmd.set),
        .clr  (sys_cmd.clr),
        .data (sys_cmd.data[N_SYS-1:0]),
        .lock (pll_lock),
        .q    (sys_q)
    );

    pclk_enable_bank #(
        .W         (N_PERIPH),
        .RSV_MASK  (PER_RSV_W),
        .LOCK_MASK ('0)
    ) u_per_bank (
        .clk  (mclk),
        .rst  (rst),
        .set  (per_cmd.set),
        .clr  (per_cmd.clr),
        .data (per_cmd.data[N_PERIPH-1:0]),
        .lock (1'b1),
        .q    (per_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (is_addr(bus_addr, A_SYS_STAT))      bus_rdata[N_SYS-1:0]    = sys_q;
        else if (is_addr(bus_addr, A_PER_STAT)) bus_rdata[N_PERIPH-1:0] = per_q;
    end

    generate
        for (genvar i = 0; i < N_PERIPH; i++) begin : g_per_gate
            pclk_gate u_gate (.clk(mclk), .en(per_q[i]), .gclk(periph_clk[i]));
        end
        for (genvar j = 0; j < N_SYS; j++) begin : g_sys_gate
            pclk_gate u_gate (.clk(mclk), .en(sys_q[j]), .gclk(sys_clk[j]));
        end
    endgenerate

endmodule

// File: tb/tb_pclk_ctrl.sv
module tb_pclk_ctrl;

    logic        mclk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pll_lock = 1'b0;
    logic [31:0] periph_clk;
    logic [1:0]  sys_clk;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 mclk = ~mclk;

    pclk_ctrl dut (
        .mclk(mclk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock(pll_lock),
        .periph_clk(periph_clk), .sys_clk(sys_clk)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge mclk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge mclk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge mclk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // sample gated outputs in the high phase of the next rising edge
    task automatic hi_phase(output logic [31:0] p, output logic [1:0] s);
        @(posedge mclk);
        #2;
        p = periph_clk; s = sys_clk;
    endtask

    task automatic t_reset;
        logic [31:0] v; logic [31:0] p; logic [1:0] s;
        rst = 1'b1;
        repeat (3) @(negedge mclk);
        rst = 1'b0;
        rd(3'd6, v); check("R6 periph status after reset", v, 32'h0);
        rd(3'd2, v); check("R6 system status after reset", v, 32'h0);
        hi_phase(p, s);
        check("R6 periph clocks quiet", p, 32'h0);
        check("R6 system clocks quiet", {30'd0, s}, 32'h0);
    endtask

    task automatic t_enable;
        logic [31:0] v;
        wr(3'd4, 32'h0000_F0F0);
        rd(3'd6, v); check("R1 enable write", v, 32'h0000_F0F0);
        wr(3'd4, 32'h0000_0100);
        rd(3'd6, v); check("R1 zeros keep state", v, 32'h0000_F1F0);
    endtask

    task automatic t_disable;
        logic [31:0] v; logic [31:0] p; logic [1:0] s;
        wr(3'd5, 32'h0000_0030);
        rd(3'd6, v); check("R2 disable write", v, 32'h0000_F1C0);
        hi_phase(p, s);
        check("R9 outputs follow enable bits", p, 32'h0000_F1C0);
    endtask

    task automatic t_ignored;
        logic [31:0] v;
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd6, v); check("R3 status/unused writes ignored (periph)", v, 32'h0000_F1C0);
        rd(3'd2, v); check("R3 status/unused writes ignored (sys)", v, 32'h0);
        rd(3'd7, v); check("R3 unused address reads 0", v, 32'h0);
    endtask

    task automatic t_reserved;
        logic [31:0] v; logic [31:0] p; logic [1:0] s;
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd6, v); check("R5 reserved bits read 0", v, 32'hFFFF_FFFC);
        hi_phase(p, s);
        check("R5 reserved outputs never pulse", p, 32'hFFFF_FFFC);
    endtask

    task automatic t_gate_timing;
        logic [31:0] p; logic [1:0] s; logic [31:0] v;
        @(negedge mclk);
        bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h8000_0004;
        hi_phase(p, s);
        check("R4 pulse at capturing edge keeps old state", p, 32'hFFFF_FFFC);
        @(negedge mclk);
        bus_wr = 1'b0;
        hi_phase(p, s);
        check("R4 disabled clock stopped at next edge", p, 32'h7FFF_FFF8);
        @(negedge mclk);
        bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 32'h0000_0004;
        @(negedge mclk);
        bus_wr = 1'b0;
        hi_phase(p, s);
        check("R4 re-enabled clock runs", p, 32'h7FFF_FFFC);
        rd(3'd6, v); check("R4 status after re-enable", v, 32'h7FFF_FFFC);
    endtask

    task automatic t_sys_lock;
        logic [31:0] v; logic [31:0] p; logic [1:0] s;
        pll_lock = 1'b0;
        wr(3'd0, 32'h0000_0003);
        rd(3'd2, v); check("R8 USB enable dropped without lock", v, 32'h2);
        check("R7 lock-free system bit set", v & 32'h2, 32'h2);
        pll_lock = 1'b1;
        wr(3'd0, 32'h0000_0001);
        rd(3'd2, v); check("R8 USB enable with lock", v, 32'h3);
        hi_phase(p, s);
        check("R9 system clocks run", {30'd0, s}, 32'h3);
        @(negedge mclk);
        pll_lock = 1'b0;
        @(negedge mclk);
        rd(3'd2, v); check("R8 lock loss clears USB", v, 32'h2);
        @(negedge mclk);
        pll_lock = 1'b0; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h1;
        @(negedge mclk);
        bus_wr = 1'b0;
        rd(3'd2, v); check("R8 lock loss beats enable", v, 32'h2);
        hi_phase(p, s);
        check("R8 USB output quiet", {30'd0, s}, 32'h2);
        pll_lock = 1'b1;
        wr(3'd1, 32'h0000_0002);
        rd(3'd2, v); check("R7 system disable write", v, 32'h0);
        rd(3'd6, v); check("R7 system writes leave peripherals", v, 32'h7FFF_FFFC);
    endtask

    task automatic t_reset_again;
        logic [31:0] v;
        @(negedge mclk);
        rst = 1'b1;
        @(negedge mclk);
        rst = 1'b0;
        rd(3'd6, v); check("R6 reset mid-run clears peripherals", v, 32'h0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_enable();
                t_disable();
                t_ignored();
                t_reserved();
                t_gate_timing();
                t_sys_lock();
                t_reset_again();
            end
            begin
                #(8 * 200000);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule